// File: doc/BRIEF.md
# Per-Channel Average Threshold Generator

This block sits between a matrix-transpose buffer and a fine-resolution spectral stage. It receives complex time-domain samples grouped by coarse frequency channel. Each channel's block of `2^LOG2_N` consecutive samples is complete before the next channel starts. Because total power is the same in the time and frequency domains, the mean power of one channel's block can be found before the spectral transform runs. That mean then serves as the local noise floor for the channel's fine bins.

For every sample the block forms the power, the sum of the squared real and imaginary parts. It sums one channel's powers and divides the sum by the block length with a right shift. It then multiplies the mean by an unsigned fixed-point scale factor held in a software-writable register. The threshold, the mean and the channel number are presented together with a valid flag. They stay steady until the next channel's result replaces them, so a downstream comparator can use them for the whole following channel period.

Sample intake is controlled by a three-state machine:

- `ST_WAIT_SYNC` is entered at reset. Samples are ignored until a qualified frame-start marker arrives, which moves the machine to `ST_FIRST_CHAN`.
- `ST_FIRST_CHAN` accumulates the first channel of a frame. When that channel's last sample arrives, the machine moves to `ST_STEADY`.
- `ST_STEADY` accumulates later channels while earlier results are on display.
- A frame-start marker in any state leads to `ST_FIRST_CHAN`.

Top module: `chan_thresh_gen`

## Requirements
- R1: Each accepted sample contributes the power re*re + im*im, where re and im are two's-complement `DATA_W`-bit values. The powers of `2^LOG2_N` samples are summed, and `mean_out` shows that sum shifted right by `LOG2_N` (floor). A result appears on the third rising edge, counting as the first the edge that accepts the channel's last sample.
- R2: `thr_out` equals floor(mean * S / 2^`FRAC_W`), where S is the scale register. When that value does not fit in `OUT_W` bits, `thr_out` is all ones.
- R3: The scale register holds 48 after reset. A cycle with `cfg_we` high loads it with `cfg_wdata[SCALE_W-1:0]`, and the upper bits of `cfg_wdata` are ignored. A result is scaled with the register value in force just before the edge that presents it.
- R4: A cycle with `in_valid` low has no effect, whatever `in_sync`, `in_re` and `in_im` carry. In particular, no marker is seen and no sample is counted.
- R5: After reset, samples arriving before the first frame-start marker are discarded, and `thr_valid` stays low.
- R6: A sample with `in_valid` and `in_sync` both high is sample 0 of channel 0. It discards any partial sum. `thr_valid` falls on the third rising edge, counting the edge that accepts it.
- R7: `thr_chan` gives the index of the channel whose result is shown. Channels are numbered from 0 at each marker and wrap modulo `2^CHAN_W`.
- R8: Once a result is presented, `thr_out`, `mean_out`, `thr_chan` and `thr_valid` hold unchanged until the next result or restart.
- R9: During and right after reset, `thr_valid` is 0 and `thr_out`, `mean_out` and `thr_chan` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sync | input | 1 | Frame-start marker, qualified by `in_valid` |
| in_re | input | DATA_W | Real part, two's complement |
| in_im | input | DATA_W | Imaginary part, two's complement |
| cfg_we | input | 1 | Scale register write enable |
| cfg_wdata | input | REG_W | Scale register write data (low `SCALE_W` bits used) |
| thr_valid | output | 1 | Result on the outputs is valid |
| thr_chan | output | CHAN_W | Channel index of the shown result |
| thr_out | output | OUT_W | Scaled, saturated threshold |
| mean_out | output | 2*DATA_W | Channel mean power |

## Verification
The bench builds the block with `LOG2_N = 3` (eight samples per channel) and `CHAN_W = 2` (four channels). It keeps the 18-bit sample parts and the 18-bit scale with 9 fractional bits. With those values, a frame wraps the channel index within a few dozen cycles. Restarts in mid-channel and marker pulses during gaps take only a few cycles to set up. Full-scale negative samples, combined with a large scale value, reach the saturation path, while the true-width arithmetic still bears on every result.

// File: rtl/chan_thresh_pkg.sv
package chan_thresh_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_SYNC  = 2'd0,
        ST_FIRST_CHAN = 2'd1,
        ST_STEADY     = 2'd2
    } acc_state_t;

endpackage

// File: rtl/ctg_power.sv
module ctg_power #(
    parameter int DATA_W = 18,
    localparam int PWR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    output logic              pw_valid,
    output logic              pw_sync,
    output logic [PWR_W-1:0]  pw_data
);

    logic [DATA_W-1:0] comp   [2];
    logic [PWR_W-1:0]  sq_mag [2];

    assign comp[0] = in_re;
    assign comp[1] = in_im;

    // Square each part after sign extension to the power width.
    for (genvar g = 0; g < 2; g++) begin : g_square
        logic signed [PWR_W-1:0] ext;
        logic signed [PWR_W-1:0] sq;
        assign ext       = {{DATA_W{comp[g][DATA_W-1]}}, comp[g]};
        assign sq        = ext * ext;
        assign sq_mag[g] = $unsigned(sq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_valid <= 1'b0;
            pw_sync  <= 1'b0;
            pw_data  <= '0;
        end else begin
            pw_valid <= in_valid;
            pw_sync  <= in_valid & in_sync;
            if (in_valid) begin
                pw_data <= sq_mag[0] + sq_mag[1];
            end
        end
    end

endmodule

// File: rtl/ctg_accum.sv
module ctg_accum
    import chan_thresh_pkg::*;
#(
    parameter int PWR_W  = 36,
    parameter int LOG2_N = 15,
    parameter int CHAN_W = 12,
    localparam int ACC_W = PWR_W + LOG2_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pw_valid,
    input  logic              pw_sync,
    input  logic [PWR_W-1:0]  pw_data,
    output logic              done,
    output logic              restart,
    output logic [ACC_W-1:0]  sum_out,
    output logic [CHAN_W-1:0] done_chan
);

    acc_state_t        state_q, state_d;
    logic [ACC_W-1:0]  acc_q;
    logic [LOG2_N-1:0] cnt_q;
    logic [CHAN_W-1:0] chan_q;
    logic [ACC_W-1:0]  pw_ext;
    logic              armed;
    logic              take;
    logic              last_hit;

    assign pw_ext   = {{LOG2_N{1'b0}}, pw_data};
    assign armed    = (state_q != ST_WAIT_SYNC);
    assign take     = pw_valid & ~pw_sync & armed;
    assign last_hit = take & (&cnt_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SYNC: begin
                if (pw_sync) state_d = ST_FIRST_CHAN;
            end
            ST_FIRST_CHAN: begin
                if (pw_sync)       state_d = ST_FIRST_CHAN;
                else if (last_hit) state_d = ST_STEADY;
            end
            ST_STEADY: begin
                if (pw_sync) state_d = ST_FIRST_CHAN;
            end
            default: state_d = ST_WAIT_SYNC;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            chan_q    <= '0;
            done      <= 1'b0;
            restart   <= 1'b0;
            sum_out   <= '0;
            done_chan <= '0;
        end else begin
            done    <= last_hit;
            restart <= pw_sync;
            if (pw_sync) begin
                acc_q  <= pw_ext;
                cnt_q  <= LOG2_N'(1);
                chan_q <= '0;
            end else if (last_hit) begin
                sum_out   <= acc_q + pw_ext;
                done_chan <= chan_q;
                acc_q     <= '0;
                cnt_q     <= '0;
                chan_q    <= chan_q + CHAN_W'(1);
            end else if (take) begin
                acc_q <= acc_q + pw_ext;
                cnt_q <= cnt_q + LOG2_N'(1);
            end
        end
    end

endmodule

// File: rtl/ctg_scaler.sv
module ctg_scaler #(
    parameter int PWR_W   = 36,
    parameter int LOG2_N  = 15,
    parameter int CHAN_W  = 12,
    parameter int SCALE_W = 18,
    parameter int FRAC_W  = 9,
    parameter int OUT_W   = 32,
    localparam int ACC_W   = PWR_W + LOG2_N,
    localparam int PROD_W  = PWR_W + SCALE_W,
    localparam int SHIFT_W = PROD_W - FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  logic               restart,
    input  logic [ACC_W-1:0]   sum_in,
    input  logic [CHAN_W-1:0]  chan_in,
    input  logic [SCALE_W-1:0] scale,
    output logic               thr_valid,
    output logic [CHAN_W-1:0]  thr_chan,
    output logic [OUT_W-1:0]   thr_out,
    output logic [PWR_W-1:0]   mean_out
);

    logic [PWR_W-1:0]   mean_w;
    logic [PROD_W-1:0]  prod;
    logic [SHIFT_W-1:0] shifted;
    logic [OUT_W-1:0]   thr_w;
    logic               unused_lsb;
    logic               unused_frac;

    assign mean_w      = sum_in[ACC_W-1:LOG2_N];
    assign unused_lsb  = ^sum_in[LOG2_N-1:0];
    assign prod        = {{SCALE_W{1'b0}}, mean_w} * {{PWR_W{1'b0}}, scale};
    assign shifted     = prod[PROD_W-1:FRAC_W];
    assign unused_frac = ^prod[FRAC_W-1:0];

    // Clamp only when the shifted product can be wider than the output.
    if (SHIFT_W > OUT_W) begin : g_sat
        assign thr_w = (|shifted[SHIFT_W-1:OUT_W]) ? '1 : shifted[OUT_W-1:0];
    end else begin : g_nosat
        assign thr_w = OUT_W'(shifted);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_valid <= 1'b0;
            thr_chan  <= '0;
            thr_out   <= '0;
            mean_out  <= '0;
        end else if (restart) begin
            thr_valid <= 1'b0;
        end else if (done) begin
            thr_valid <= 1'b1;
            thr_chan  <= chan_in;
            thr_out   <= thr_w;
            mean_out  <= mean_w;
        end
    end

endmodule

// File: rtl/chan_thresh_gen.sv
module chan_thresh_gen #(
    parameter int DATA_W      = 18,
    parameter int LOG2_N      = 15,
    parameter int CHAN_W      = 12,
    parameter int SCALE_W     = 18,
    parameter int FRAC_W      = 9,
    parameter int REG_W       = 32,
    parameter int OUT_W       = 32,
    parameter int SCALE_RESET = 48,
    localparam int PWR_W = 2 * DATA_W,
    localparam int ACC_W = PWR_W + LOG2_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              thr_valid,
    output logic [CHAN_W-1:0] thr_chan,
    output logic [OUT_W-1:0]  thr_out,
    output logic [PWR_W-1:0]  mean_out
);

    logic [SCALE_W-1:0] scale_q;
    logic               unused_cfg;
    logic               pw_valid;
    logic               pw_sync;
    logic [PWR_W-1:0]   pw_data;
    logic               done;
    logic               restart;
    logic [ACC_W-1:0]   sum;
    logic [CHAN_W-1:0]  done_chan;

    assign unused_cfg = ^cfg_wdata[REG_W-1:SCALE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q <= SCALE_W'(SCALE_RESET);
        end else if (cfg_we) begin
            scale_q <= cfg_wdata[SCALE_W-1:0];
        end
    end

    ctg_power #(.DATA_W(DATA_W)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .in_re    (in_re),
        .in_im    (in_im),
        .pw_valid (pw_valid),
        .pw_sync  (pw_sync),
        .pw_data  (pw_data)
    );

    ctg_accum #(
        .PWR_W  (PWR_W),
        .LOG2_N (LOG2_N),
        .CHAN_W (CHAN_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .pw_valid  (pw_valid),
        .pw_sync   (pw_sync),
        .pw_data   (pw_data),
        .done      (done),
        .restart   (restart),
        .sum_out   (sum),
        .done_chan (done_chan)
    );

    ctg_scaler #(
        .PWR_W   (PWR_W),
        .LOG2_N  (LOG2_N),
        .CHAN_W  (CHAN_W),
        .SCALE_W (SCALE_W),
        .FRAC_W  (FRAC_W),
        .OUT_W   (OUT_W)
    ) u_scaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .restart   (restart),
        .sum_in    (sum),
        .chan_in   (done_chan),
        .scale     (scale_q),
        .thr_valid (thr_valid),
        .thr_chan  (thr_chan),
        .thr_out   (thr_out),
        .mean_out  (mean_out)
    );

endmodule

// File: rtl/chan_thresh_gen_chk.sv
module chan_thresh_gen_chk #(
    parameter int CHAN_W  = 12,
    parameter int SCALE_W = 18,
    parameter int REG_W   = 32,
    parameter int OUT_W   = 32,
    parameter int PWR_W   = 36
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_sync,
    input logic               cfg_we,
    input logic [REG_W-1:0]   cfg_wdata,
    input logic               thr_valid,
    input logic [CHAN_W-1:0]  thr_chan,
    input logic [OUT_W-1:0]   thr_out,
    input logic [PWR_W-1:0]   mean_out,
    input logic [SCALE_W-1:0] scale_q
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R3
    scale_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (scale_q == $past(cfg_wdata[SCALE_W-1:0])));

    // R2
    zero_mean_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_valid && mean_out == '0) |-> (thr_out == '0));

    // R4
    idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !$past(in_valid, 3)) |-> ($stable(thr_out) && $stable(mean_out) && $stable(thr_chan) && $stable(thr_valid)));

    // R6
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |-> ##3 !thr_valid);

    // R7
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_valid && $past(thr_valid) && thr_chan != $past(thr_chan)) |-> (thr_chan == CHAN_W'($past(thr_chan) + 1'b1)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_valid && $past(thr_valid) && thr_chan == $past(thr_chan)) |-> ($stable(thr_out) && $stable(mean_out)));

endmodule

bind chan_thresh_gen chan_thresh_gen_chk #(
    .CHAN_W  (CHAN_W),
    .SCALE_W (SCALE_W),
    .REG_W   (REG_W),
    .OUT_W   (OUT_W),
    .PWR_W   (PWR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .thr_valid (thr_valid),
    .thr_chan  (thr_chan),
    .thr_out   (thr_out),
    .mean_out  (mean_out),
    .scale_q   (scale_q)
);

// File: tb/chan_thresh_gen_test.sv
module chan_thresh_gen_test;

    localparam int DW = 18;
    localparam int LN = 3;
    localparam int CW = 2;
    localparam int NS = 1 << LN;
    localparam int NC = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sync = 1'b0;
    logic [DW-1:0] in_re = '0;
    logic [DW-1:0] in_im = '0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          thr_valid;
    logic [CW-1:0] thr_chan;
    logic [31:0]   thr_out;
    logic [35:0]   mean_out;

    always #2 clk = ~clk;  // 250 MHz

    chan_thresh_gen #(.DATA_W(DW), .LOG2_N(LN), .CHAN_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_re(in_re), .in_im(in_im), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .thr_valid(thr_valid), .thr_chan(thr_chan), .thr_out(thr_out), .mean_out(mean_out)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string phase = "R9";

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    typedef struct {
        longint due;
        bit     rs;
        longint mean;
        int     chan;
    } ev_t;

    ev_t    evq[$];
    longint cyc = 0;
    longint m_scale = 48;
    bit     m_armed = 0;
    int     m_cnt = 0;
    int     m_chan = 0;
    longint m_sum = 0;
    bit     e_valid = 0;
    longint e_thr = 0;
    longint e_mean = 0;
    int     e_chan = 0;

    function automatic longint scaled(input longint mean, input longint s);
        longint v;
        v = (mean * s) >>> 9;
        if (v > 64'hFFFF_FFFF) v = 64'hFFFF_FFFF;
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            evq.delete();
            m_scale = 48; m_armed = 0; m_cnt = 0; m_chan = 0; m_sum = 0;
            e_valid = 0; e_thr = 0; e_mean = 0; e_chan = 0;
        end else begin
            while (evq.size() > 0 && evq[0].due == cyc) begin
                ev_t e;
                e = evq.pop_front();
                if (e.rs) begin
                    e_valid = 0;
                end else begin
                    e_valid = 1;
                    e_mean  = e.mean;
                    e_thr   = scaled(e.mean, m_scale);
                    e_chan  = e.chan;
                end
            end
            if (cfg_we) m_scale = longint'(cfg_wdata & 32'h3FFFF);
            if (in_valid) begin
                longint r;
                longint q;
                r = longint'($signed(in_re));
                q = longint'($signed(in_im));
                if (in_sync) begin
                    m_armed = 1; m_cnt = 0; m_chan = 0; m_sum = 0;
                    evq.push_back('{cyc + 2, 1'b1, 0, 0});
                end
                if (m_armed) begin
                    m_sum += r * r + q * q;
                    m_cnt++;
                    if (m_cnt == NS) begin
                        evq.push_back('{cyc + 2, 1'b0, m_sum >>> LN, m_chan});
                        m_chan = (m_chan + 1) % NC;
                        m_cnt  = 0;
                        m_sum  = 0;
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            check_eq(phase, "thr_valid R8", longint'(thr_valid), longint'(e_valid));
            check_eq(phase, "thr_out R2", longint'(thr_out), e_thr);
            check_eq(phase, "mean_out R1", longint'(mean_out), e_mean);
            check_eq(phase, "thr_chan R7", longint'(thr_chan), longint'(e_chan));
        end
    end

    logic [31:0] seed = 32'h1234_5678;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_sync = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic put(input logic [DW-1:0] re, input logic [DW-1:0] im, input bit sy);
        in_valid = 1'b1; in_sync = sy; in_re = re; in_im = im;
        @(negedge clk);
    endtask

    // kind 0: pseudo-random, 1: most negative, 2: zero, 3: small, 4: most positive
    task automatic send_chan(input int kind, input bit first, input bit gaps);
        for (int i = 0; i < NS; i++) begin
            logic [DW-1:0] re;
            logic [DW-1:0] im;
            seed = seed * 32'd1103515245 + 32'd12345;
            case (kind)
                1:       begin re = 18'h20000; im = 18'h20000; end
                2:       begin re = '0; im = '0; end
                3:       begin re = DW'(i + 1); im = DW'(2); end
                4:       begin re = 18'h1FFFF; im = 18'h1FFFF; end
                default: begin re = seed[25:8]; im = seed[31:14]; end
            endcase
            if (gaps) begin
                in_valid = 1'b0; in_sync = 1'b1;
                in_re = 18'h20000; in_im = 18'h20000;
                @(negedge clk);
            end
            put(re, im, first && i == 0);
        end
        in_valid = 1'b0; in_sync = 1'b0;
    endtask

    task automatic write_scale(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values while reset is held and right after release
        check_eq("R9", "valid in reset", longint'(thr_valid), 0);
        check_eq("R9", "thr in reset", longint'(thr_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R9", "mean after reset", longint'(mean_out), 0);
        check_eq("R9", "chan after reset", longint'(thr_chan), 0);

        phase = "R5";
        send_chan(1, 1'b0, 1'b0);
        send_chan(0, 1'b0, 1'b0);
        idle(4);
        check_eq("R5", "valid before marker", longint'(thr_valid), 0);

        phase = "R1";
        send_chan(0, 1'b1, 1'b0);
        idle(2);
        // R3: default scale 48 applied to an independent recomputation
        check_eq("R3", "default scale use", longint'(thr_out), scaled(longint'(mean_out), 48));
        check_eq("R1", "first result valid", longint'(thr_valid), 1);
        phase = "R7";
        send_chan(1, 1'b1, 1'b0);
        send_chan(3, 1'b0, 1'b0);
        send_chan(4, 1'b0, 1'b0);
        send_chan(0, 1'b0, 1'b0);
        send_chan(2, 1'b0, 1'b0);
        send_chan(0, 1'b0, 1'b0);
        phase = "R8";
        idle(12);

        phase = "R3";
        write_scale(32'hFFFC_0200);
        idle(3);
        send_chan(1, 1'b1, 1'b0);
        idle(2);
        check_eq("R2", "full-scale at unity", longint'(thr_out), 64'hFFFF_FFFF);
        send_chan(0, 1'b0, 1'b0);
        idle(4);

        phase = "R2";
        write_scale(32'h0003_FFFF);
        idle(3);
        send_chan(4, 1'b0, 1'b0);
        idle(2);
        check_eq("R2", "saturated thr", longint'(thr_out), 64'hFFFF_FFFF);
        write_scale(32'h0000_0001);
        idle(3);
        send_chan(3, 1'b0, 1'b0);
        send_chan(0, 1'b0, 1'b0);
        idle(4);

        phase = "R4";
        write_scale(32'd48);
        idle(3);
        send_chan(0, 1'b1, 1'b1);
        send_chan(3, 1'b0, 1'b1);
        idle(2);
        check_eq("R4", "chan after gaps", longint'(thr_chan), 1);

        phase = "R6";
        send_chan(0, 1'b0, 1'b0);
        put(18'h00100, 18'h00200, 1'b0);
        put(18'h00300, 18'h3FF00, 1'b0);
        put(18'h01000, 18'h01000, 1'b1);
        idle(2);
        check_eq("R6", "valid dropped", longint'(thr_valid), 0);
        send_chan(0, 1'b0, 1'b0);
        send_chan(3, 1'b1, 1'b0);
        send_chan(1, 1'b0, 1'b0);
        idle(6);
        check_eq("R6", "chan after restart", longint'(thr_chan), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R8 watchdog: actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule